// File: doc/BRIEF.md
# Hierarchical Configuration Access Router

This block takes configuration read and write requests and steers each one to a single function register port. The ports sit on a primary bus and on several secondary buses that hang behind bridges. A 24-bit request address carries three fields. The bus number is in the top byte, the device/function index is in the middle byte, and the register offset is in the low byte. The router finds the bus whose current number matches the request. It then finds the slot on that bus that the index names. The selected function port sees the access in the same cycle that the request is accepted.

The router holds the bridges themselves, and software renumbers the secondary buses at run time through them. Each bridge has a small read-only header and a programmable secondary bus number. An access that finds no bus or no slot is an abort. A read that aborts returns all-ones of the access width. A write that aborts changes nothing.

Requests use a valid/ready handshake. Only one request can be outstanding at a time. `req_ready` is high when no response is held, or when the held response is being taken in the same cycle. Each accepted request gives exactly one response, one cycle later. The response stays on `rsp_valid`/`rsp_rdata`/`rsp_abort` without change until `rsp_ready` is high. While `req_valid` is high and `req_ready` is low, the requester must hold the request fields steady.

Top module: `cfg_access_router`

## Requirements
- R1: `req_addr[23:16]` is the bus number, `req_addr[15:8]` the device/function index and `req_addr[7:0]` the register offset. The offset, the size code and the write data reach the selected function port unchanged.
- R2: The bus search gives priority to the primary bus, whose number is fixed at 0. After it come the secondary buses in ascending bridge order. The first bus whose number matches wins.
- R3: On any bus, index `DEVFN_MIN + 8*s` for `s < SLOTS` hits function slot `s`. This drives the single bit `bus*SLOTS + s` of `fn_sel`, where the primary bus is 0 and secondary bus `j+1` sits behind bridge `j`. Any other index is a miss on a secondary bus.
- R4: When a read misses, the response has `rsp_abort=1` and data 0xFF, 0xFFFF or 0xFFFFFFFF for size code 0 (1 byte), 1 (2 bytes) or 2 (4 bytes).
- R5: When a write misses, the response has `rsp_abort=1`. `fn_sel` stays zero, and no bridge register changes.
- R6: A write at offset 0x19 to a bridge loads that bridge's secondary bus number from `wdata[7:0]`.
- R7: A 2- or 4-byte write at offset 0x18 to a bridge loads the bus number from `wdata[15:8]`. A 1-byte write at 0x18, and a write at any other offset, leave the bridge unchanged.
- R8: Bridge `j` answers on the primary bus at index `DEVFN_MIN + 8*(SLOTS+j)`. Its header bytes read as follows: 0x00–0x03 give `BRIDGE_ID` in little-endian order, 0x0A reads 0x04, 0x0B reads 0x06, 0x0E reads 0x81, 0x18 reads 0, 0x19 reads the secondary number, and every other byte reads 0.
- R9: After reset, every secondary bus number is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R10: `req_ready` equals `!rsp_valid || rsp_ready`. An accepted request sets `rsp_valid` on the next cycle. A held response keeps its data and abort flag until it is taken.
- R11: Read data is zero above the access width, and a write response carries zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | 24 | Bus, device/function, offset |
| req_we | input | 1 | 1 = write |
| req_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| req_wdata | input | 32 | Write data, LSB-aligned |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 32 | Read data, LSB-aligned |
| rsp_abort | output | 1 | No target matched |
| fn_sel | output | NTGT | One-hot function port select |
| fn_we | output | 1 | Write strobe to the selected port |
| fn_off | output | 8 | Register offset to the port |
| fn_size | output | 2 | Size code to the port |
| fn_wdata | output | 32 | Write data to the port |
| fn_rdata | input | NTGT*32 | Combinational read data from each port |

## Verification
The assertions rely on two properties of the inputs. The requester keeps the request fields stable while it waits on `req_ready`, and it never sends size code 3. The abort-data check also assumes that the response belongs to the most recently accepted request. The bench meets these conditions by driving every field on a falling edge and holding it until acceptance. It uses only the three defined size codes. The function stubs answer combinationally with a word built from the target index, the offset and the last written value, so every expected value can be worked out without the design.

// File: rtl/cfgr_pkg.sv
package cfgr_pkg;

  typedef struct packed {
    logic [7:0] bus;
    logic [7:0] devfn;
    logic [7:0] off;
  } cfg_addr_t;

  // size code 0/1/2 -> 1/2/4 bytes; code 3 treated as 4 bytes
  function automatic logic [31:0] width_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    width_mask = 32'h0000_00FF;
      2'd1:    width_mask = 32'h0000_FFFF;
      default: width_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/cfgr_bus_select.sv
module cfgr_bus_select #(
  parameter int NUM_SEC = 2,
  localparam int BIDX_W = $clog2(NUM_SEC + 1)
) (
  input  logic [7:0]           req_bus,
  input  logic [NUM_SEC*8-1:0] sec_num,
  output logic                 bus_hit,
  output logic [BIDX_W-1:0]    bus_idx
);

  logic [NUM_SEC:1] match;

  for (genvar j = 1; j <= NUM_SEC; j++) begin : g_match
    assign match[j] = (sec_num[(j-1)*8 +: 8] == req_bus);
  end

  // lowest index wins: scan downward, primary overrides last
  always_comb begin
    bus_hit = 1'b0;
    bus_idx = '0;
    for (int i = NUM_SEC; i >= 1; i--) begin
      if (match[i]) begin
        bus_hit = 1'b1;
        bus_idx = BIDX_W'(i);
      end
    end
    if (req_bus == 8'h00) begin
      bus_hit = 1'b1;
      bus_idx = '0;
    end
  end

endmodule

// File: rtl/cfgr_slot_decode.sv
module cfgr_slot_decode #(
  parameter int SLOTS     = 4,
  parameter int NUM_SEC   = 2,
  parameter int DEVFN_MIN = 8,
  localparam int SLOT_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int BR_W     = (NUM_SEC > 1) ? $clog2(NUM_SEC) : 1
) (
  input  logic [7:0]        devfn,
  input  logic              on_primary,
  output logic              fn_hit,
  output logic [SLOT_W-1:0] fn_slot,
  output logic              br_hit,
  output logic [BR_W-1:0]   br_idx
);

  localparam logic [4:0] FN_END = 5'(SLOTS);
  localparam logic [4:0] BR_END = 5'(SLOTS + NUM_SEC);

  logic [8:0] delta;
  logic       aligned;
  logic [4:0] slot_num;

  assign delta    = {1'b0, devfn} - 9'(DEVFN_MIN);
  assign aligned  = !delta[8] && (delta[2:0] == 3'd0);
  assign slot_num = delta[7:3];

  assign fn_hit  = aligned && (slot_num < FN_END);
  assign fn_slot = SLOT_W'(slot_num);
  assign br_hit  = on_primary && aligned && (slot_num >= FN_END) && (slot_num < BR_END);
  assign br_idx  = BR_W'(slot_num - FN_END);

endmodule

// File: rtl/cfgr_bridge_bank.sv
module cfgr_bridge_bank
  import cfgr_pkg::*;
#(
  parameter int          NUM_SEC   = 2,
  parameter logic [31:0] BRIDGE_ID = 32'h0A5C_7E11,
  localparam int         BR_W      = (NUM_SEC > 1) ? $clog2(NUM_SEC) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [BR_W-1:0]      idx,
  input  logic [7:0]           off,
  input  logic [1:0]           size,
  input  logic [31:0]          wdata,
  output logic [31:0]          rd_data,
  output logic [NUM_SEC*8-1:0] sec_num
);

  logic [7:0] num_q [NUM_SEC];

  for (genvar j = 0; j < NUM_SEC; j++) begin : g_br
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        num_q[j] <= 8'h00;
      end else if (wr_en && (idx == BR_W'(j))) begin
        if (off == 8'h19)
          num_q[j] <= wdata[7:0];
        else if ((off == 8'h18) && (size != 2'd0))
          num_q[j] <= wdata[15:8];
      end
    end
    assign sec_num[j*8 +: 8] = num_q[j];
  end

  function automatic logic [7:0] hdr_byte(input logic [7:0] a, input logic [7:0] num);
    case (a)
      8'h00:   hdr_byte = BRIDGE_ID[7:0];
      8'h01:   hdr_byte = BRIDGE_ID[15:8];
      8'h02:   hdr_byte = BRIDGE_ID[23:16];
      8'h03:   hdr_byte = BRIDGE_ID[31:24];
      8'h0A:   hdr_byte = 8'h04;
      8'h0B:   hdr_byte = 8'h06;
      8'h0E:   hdr_byte = 8'h81;
      8'h19:   hdr_byte = num;
      default: hdr_byte = 8'h00;
    endcase
  endfunction

  logic [7:0]  sel_num;
  logic [31:0] word;

  always_comb begin
    sel_num = num_q[idx];
    for (int b = 0; b < 4; b++)
      word[b*8 +: 8] = hdr_byte(off + 8'(b), sel_num);
    rd_data = word & width_mask(size);
  end

endmodule

// File: rtl/cfg_access_router.sv
module cfg_access_router
  import cfgr_pkg::*;
#(
  parameter int          NUM_SEC   = 2,
  parameter int          SLOTS     = 4,
  parameter int          DEVFN_MIN = 8,
  parameter logic [31:0] BRIDGE_ID = 32'h0A5C_7E11,
  localparam int         NTGT      = (1 + NUM_SEC) * SLOTS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [23:0]       req_addr,
  input  logic              req_we,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_abort,
  output logic [NTGT-1:0]   fn_sel,
  output logic              fn_we,
  output logic [7:0]        fn_off,
  output logic [1:0]        fn_size,
  output logic [31:0]       fn_wdata,
  input  logic [NTGT*32-1:0] fn_rdata
);

  localparam int BIDX_W = $clog2(NUM_SEC + 1);
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int BR_W   = (NUM_SEC > 1) ? $clog2(NUM_SEC) : 1;
  localparam int TW     = (NTGT > 1) ? $clog2(NTGT) : 1;

  cfg_addr_t a;
  assign a = req_addr;

  logic                 accept;
  logic                 bus_hit, fn_hit, br_hit, on_primary, hit;
  logic [BIDX_W-1:0]    bus_idx;
  logic [SLOT_W-1:0]    fn_slot;
  logic [BR_W-1:0]      br_idx;
  logic [NUM_SEC*8-1:0] sec_num;
  logic [31:0]          br_rd, fn_word, mask, rsp_d;
  logic [TW-1:0]        tgt;
  logic                 br_wr;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  cfgr_bus_select #(.NUM_SEC(NUM_SEC)) bus_sel_i (
    .req_bus (a.bus),
    .sec_num (sec_num),
    .bus_hit (bus_hit),
    .bus_idx (bus_idx)
  );

  assign on_primary = bus_hit && (bus_idx == '0);

  cfgr_slot_decode #(.SLOTS(SLOTS), .NUM_SEC(NUM_SEC), .DEVFN_MIN(DEVFN_MIN)) slot_i (
    .devfn      (a.devfn),
    .on_primary (on_primary),
    .fn_hit     (fn_hit),
    .fn_slot    (fn_slot),
    .br_hit     (br_hit),
    .br_idx     (br_idx)
  );

  assign hit   = bus_hit && (fn_hit || br_hit);
  assign br_wr = accept && req_we && br_hit;

  cfgr_bridge_bank #(.NUM_SEC(NUM_SEC), .BRIDGE_ID(BRIDGE_ID)) bridge_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (br_wr),
    .idx     (br_idx),
    .off     (a.off),
    .size    (req_size),
    .wdata   (req_wdata),
    .rd_data (br_rd),
    .sec_num (sec_num)
  );

  // function port side
  assign tgt      = TW'(int'(bus_idx) * SLOTS + int'(fn_slot));
  assign fn_sel   = (accept && bus_hit && fn_hit) ? ({{(NTGT-1){1'b0}}, 1'b1} << tgt) : '0;
  assign fn_we    = req_we;
  assign fn_off   = a.off;
  assign fn_size  = req_size;
  assign fn_wdata = req_wdata;
  assign fn_word  = fn_rdata[int'(tgt)*32 +: 32];
  assign mask     = width_mask(req_size);

  always_comb begin
    if (!hit)
      rsp_d = req_we ? 32'h0 : mask;
    else if (req_we)
      rsp_d = 32'h0;
    else if (fn_hit)
      rsp_d = fn_word & mask;
    else
      rsp_d = br_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_abort <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rsp_d;
      rsp_abort <= !hit;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/cfg_access_router_chk.sv
module cfg_access_router_chk
  import cfgr_pkg::*;
#(
  parameter int NTGT = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            req_we,
  input logic [1:0]      req_size,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [31:0]     rsp_rdata,
  input logic            rsp_abort,
  input logic [NTGT-1:0] fn_sel
);

  logic       last_we;
  logic [1:0] last_size;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_we   <= 1'b0;
      last_size <= 2'd0;
    end else if (req_valid && req_ready) begin
      last_we   <= req_we;
      last_size <= req_size;
    end
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fn_sel)); // R3

  AST_SEL_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (|fn_sel) |-> (req_valid && req_ready)); // R10

  AST_RSP_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid); // R10

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_abort))); // R10

  AST_ABORT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_abort && !last_we) |-> (rsp_rdata == width_mask(last_size))); // R4

  AST_WRITE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && last_we) |-> (rsp_rdata == 32'h0)); // R11

  AST_READ_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !last_we) |-> ((rsp_rdata & ~width_mask(last_size)) == 32'h0)); // R11

endmodule

bind cfg_access_router cfg_access_router_chk #(.NTGT(NTGT)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_we    (req_we),
  .req_size  (req_size),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .rsp_abort (rsp_abort),
  .fn_sel    (fn_sel)
);

// File: tb/cfg_access_router_tb_top.sv
module cfg_access_router_tb_top;

  localparam int NUM_SEC = 2;
  localparam int SLOTS   = 4;
  localparam int NTGT    = (1 + NUM_SEC) * SLOTS;
  localparam logic [31:0] BID = 32'h0A5C_7E11;
  localparam logic [7:0] BR0 = 8'd40;  // 8 + 8*(4+0)
  localparam logic [7:0] BR1 = 8'd48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, rsp_ready = 1'b1;
  logic [23:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_abort, fn_we;
  logic [31:0] rsp_rdata, fn_wdata;
  logic [NTGT-1:0] fn_sel;
  logic [7:0] fn_off;
  logic [1:0] fn_size;
  logic [NTGT*32-1:0] fn_rdata;

  always #2 clk = ~clk;

  cfg_access_router #(.NUM_SEC(NUM_SEC), .SLOTS(SLOTS), .DEVFN_MIN(8), .BRIDGE_ID(BID)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_abort(rsp_abort),
    .fn_sel(fn_sel), .fn_we(fn_we), .fn_off(fn_off), .fn_size(fn_size),
    .fn_wdata(fn_wdata), .fn_rdata(fn_rdata)
  );

  // function register stubs
  logic [15:0] stub_q [NTGT];
  always_ff @(posedge clk or negedge rst_n) begin
    for (int t = 0; t < NTGT; t++) begin
      if (!rst_n) stub_q[t] <= 16'h0;
      else if (fn_sel[t] && fn_we) stub_q[t] <= fn_wdata[15:0];
    end
  end
  for (genvar t = 0; t < NTGT; t++) begin : g_stub
    assign fn_rdata[t*32 +: 32] = {8'(t), fn_off, stub_q[t]};
  end

  int n_chk = 0, n_bad = 0;
  logic [15:0] mdl [NTGT];
  bit done = 0;

  function automatic logic [31:0] msk(input logic [1:0] sz);
    return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [NTGT-1:0] oh(input int t);
    return NTGT'(1) << t;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic we, input logic [7:0] bus, input logic [7:0] dfn,
                      input logic [7:0] off, input logic [1:0] sz, input logic [31:0] wd,
                      output logic [31:0] rd, output logic ab, output logic [NTGT-1:0] sel);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = {bus, dfn, off};
    req_size = sz; req_wdata = wd; rsp_ready = 1'b1;
    #1 sel = fn_sel;
    @(posedge clk);
    @(negedge clk);
    rd = rsp_rdata; ab = rsp_abort;
    req_valid = 1'b0;
  endtask

  // read and compare data, abort flag, select
  task automatic rd_chk(input string tag, input logic [7:0] bus, input logic [7:0] dfn,
                        input logic [7:0] off, input logic [1:0] sz, input logic [31:0] exp_d,
                        input logic exp_ab, input logic [NTGT-1:0] exp_sel);
    logic [31:0] d; logic ab; logic [NTGT-1:0] s;
    xfer(1'b0, bus, dfn, off, sz, 32'h0, d, ab, s);
    chk({tag, " data"}, d, exp_d);
    chk({tag, " abort"}, 32'(ab), 32'(exp_ab));
    chk({tag, " sel"}, 32'(s), 32'(exp_sel));
  endtask

  task automatic wr(input logic [7:0] bus, input logic [7:0] dfn, input logic [7:0] off,
                    input logic [1:0] sz, input logic [31:0] wd, input string tag,
                    input logic exp_ab, input logic [NTGT-1:0] exp_sel);
    logic [31:0] d; logic ab; logic [NTGT-1:0] s;
    xfer(1'b1, bus, dfn, off, sz, wd, d, ab, s);
    chk({tag, " wr abort"}, 32'(ab), 32'(exp_ab));
    chk({tag, " wr sel"}, 32'(s), 32'(exp_sel));
    chk({tag, " wr data zero R11"}, d, 32'h0);
  endtask

  function automatic logic [31:0] stub_exp(input int t, input logic [7:0] off, input logic [1:0] sz);
    return {8'(t), off, mdl[t]} & msk(sz);
  endfunction

  task automatic t_reset();
    chk("R9 rsp_valid after reset", 32'(rsp_valid), 32'h0);
    chk("R9 req_ready after reset", 32'(req_ready), 32'h1);
    rd_chk("R9 bridge0 number", 8'd0, BR0, 8'h19, 2'd0, 32'h0, 1'b0, '0);
    rd_chk("R9 bridge1 number", 8'd0, BR1, 8'h19, 2'd0, 32'h0, 1'b0, '0);
  endtask

  task automatic t_primary();
    for (int s = 0; s < SLOTS; s++)
      rd_chk("R3 primary slot", 8'd0, 8'(8 + 8*s), 8'h3C, 2'(s % 3), stub_exp(s, 8'h3C, 2'(s % 3)), 1'b0, oh(s));
    wr(8'd0, 8'd24, 8'h10, 2'd2, 32'hDEAD_BEEF, "R1 primary slot2", 1'b0, oh(2));
    mdl[2] = 16'hBEEF;
    rd_chk("R1 offset and data path", 8'd0, 8'd24, 8'h5A, 2'd2, stub_exp(2, 8'h5A, 2'd2), 1'b0, oh(2));
    rd_chk("R11 half read width", 8'd0, 8'd24, 8'h5A, 2'd1, 32'h0000_BEEF, 1'b0, oh(2));
  endtask

  task automatic t_miss();
    rd_chk("R4 misaligned 1B", 8'd0, 8'd9, 8'h00, 2'd0, 32'hFF, 1'b1, '0);
    rd_chk("R4 below min 2B", 8'd0, 8'd0, 8'h00, 2'd1, 32'hFFFF, 1'b1, '0);
    rd_chk("R4 past bridges 4B", 8'd0, 8'd56, 8'h00, 2'd2, 32'hFFFF_FFFF, 1'b1, '0);
    rd_chk("R4 unknown bus", 8'd5, 8'd8, 8'h00, 2'd2, 32'hFFFF_FFFF, 1'b1, '0);
    wr(8'd5, 8'd16, 8'h00, 2'd2, 32'h1234_5678, "R5 unknown bus", 1'b1, '0);
    wr(8'd9, BR0, 8'h19, 2'd0, 32'h0000_0033, "R5 bridge via bad bus", 1'b1, '0);
    rd_chk("R5 bridge0 unchanged", 8'd0, BR0, 8'h19, 2'd0, 32'h0, 1'b0, '0);
    rd_chk("R5 stub unchanged", 8'd0, 8'd16, 8'h00, 2'd2, stub_exp(1, 8'h00, 2'd2), 1'b0, oh(1));
  endtask

  task automatic t_program();
    wr(8'd0, BR0, 8'h19, 2'd0, 32'h0000_0005, "R6 set bridge0", 1'b0, '0);
    rd_chk("R6 bridge0 readback", 8'd0, BR0, 8'h19, 2'd0, 32'h05, 1'b0, '0);
    rd_chk("R3 bus5 slot1", 8'd5, 8'd16, 8'h20, 2'd2, stub_exp(5, 8'h20, 2'd2), 1'b0, oh(5));
    rd_chk("R3 no bridge on secondary", 8'd5, BR0, 8'h0E, 2'd0, 32'hFF, 1'b1, '0);
    wr(8'd0, BR1, 8'h18, 2'd1, 32'h0000_0700, "R7 half write 0x18", 1'b0, '0);
    rd_chk("R7 bridge1 readback", 8'd0, BR1, 8'h18, 2'd1, 32'h0000_0700, 1'b0, '0);
    wr(8'd0, BR1, 8'h18, 2'd0, 32'h0000_3333, "R7 byte write 0x18", 1'b0, '0);
    wr(8'd0, BR1, 8'h0E, 2'd0, 32'h0000_0000, "R7 write header", 1'b0, '0);
    rd_chk("R7 byte write ignored", 8'd0, BR1, 8'h19, 2'd0, 32'h07, 1'b0, '0);
    rd_chk("R7 header unchanged", 8'd0, BR1, 8'h0E, 2'd0, 32'h81, 1'b0, '0);
    rd_chk("R3 bus7 slot3", 8'd7, 8'd32, 8'h04, 2'd0, stub_exp(11, 8'h04, 2'd0), 1'b0, oh(11));
  endtask

  task automatic t_priority();
    wr(8'd0, BR1, 8'h18, 2'd2, 32'hAB00_0500, "R7 word write 0x18", 1'b0, '0);
    rd_chk("R2 lower bridge wins", 8'd5, 8'd8, 8'h00, 2'd2, stub_exp(4, 8'h00, 2'd2), 1'b0, oh(4));
    wr(8'd0, BR0, 8'h19, 2'd0, 32'h0000_0000, "R6 bridge0 to 0", 1'b0, '0);
    rd_chk("R2 primary wins bus0", 8'd0, 8'd8, 8'h00, 2'd2, stub_exp(0, 8'h00, 2'd2), 1'b0, oh(0));
    rd_chk("R2 bus5 falls to bridge1", 8'd5, 8'd8, 8'h00, 2'd2, stub_exp(8, 8'h00, 2'd2), 1'b0, oh(8));
  endtask

  task automatic t_header();
    rd_chk("R8 header type", 8'd0, BR0, 8'h0E, 2'd0, 32'h81, 1'b0, '0);
    rd_chk("R8 class word", 8'd0, BR0, 8'h08, 2'd2, 32'h0604_0000, 1'b0, '0);
    rd_chk("R8 id word", 8'd0, BR1, 8'h00, 2'd2, BID, 1'b0, '0);
    rd_chk("R8 0x18 word", 8'd0, BR1, 8'h18, 2'd2, 32'h0000_0500, 1'b0, '0);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_we = 1'b0;
    req_addr = {8'd0, 8'd8, 8'h44}; req_size = 2'd2;
    @(posedge clk); @(negedge clk);
    chk("R10 rsp_valid after accept", 32'(rsp_valid), 32'h1);
    chk("R10 ready low while held", 32'(req_ready), 32'h0);
    req_addr = {8'd0, 8'd16, 8'h48};
    #1 chk("R10 no select while stalled", 32'(fn_sel), 32'h0);
    @(posedge clk); @(negedge clk);
    chk("R10 held data", rsp_rdata, stub_exp(0, 8'h44, 2'd2));
    rsp_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R10 second response", rsp_rdata, stub_exp(1, 8'h48, 2'd2));
    req_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R10 response drained", 32'(rsp_valid), 32'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    for (int t = 0; t < NTGT; t++) mdl[t] = 16'h0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_primary();
    t_miss();
    t_program();
    t_priority();
    t_header();
    t_backpressure();
    repeat (2) @(posedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule